// File: doc/BRIEF.md
# Byte-Lane Converter Register Port

This block is the converter-side logic behind a small parallel host port. A host sees it at two neighbouring addresses. Its lowest address bit drives the byte-select input `hiByteSel`: the base address carries low bytes and base+1 carries high bytes. To write a register, the host sends a 16-bit command word as two 8-bit writes. The low byte goes first and is held in a staging register. The high byte follows, and when it arrives the whole word is committed.

The committed word carries three fields. Bits [15:14] name the destination register. Bits [13:12] set the read pointer. Bits [11:0] hold the data. The read pointer decides what the next read returns.

- A read from the base address returns the whole 12-bit conversion result, or the whole status word, in one transfer.
- The control and test registers return only their low byte from the base address. Their upper bits need a second read from base+1.
- An 8-bit host reads any register in two steps.

The active-low strobes are sampled on the system clock. Each action fires on the rising edge of its strobe, and only while chip select is low. Conversion results arrive from a converter stub through a one-cycle load pulse. A corrupted test register is restored by writing the word 16'h0020.

Top module: `adcRegPort`

## Requirements
- R1: After reset, `dataOe` is 0 and `dataOut` is 0. The test register holds 12'h020, the control register holds 0, the read pointer selects the result, and both status flags are 0.
- R2: A write to the low byte (`hiByteSel`=0) only stages the byte. No register visible at the port changes until a high-byte write commits it.
- R3: A high-byte write commits the word {high byte, staged byte}. Word bits [15:14] pick the destination: 00 is the test register, 01 is the control register, and 10 or 11 writes no register. Bits [13:12] load the read pointer: 0 is result, 1 is status, 2 is control, 3 is test. Bits [11:0] are the data written.
- R4: Committing the word 16'h0020 restores the test register to its default 12'h020, whatever it held before.
- R5: A high-byte write with no low-byte write since the last commit reuses the byte still held in staging.
- R6: Read and write strobes are ignored while `csN` is high.
- R7: A low-address read with the pointer at result or status returns all 12 bits of that value.
- R8: A low-address read with the pointer at control or test returns {4'h0, value[7:0]}. A high-address read returns {4'h0, value[11:8]} for any pointer.
- R9: `dataOe` is 1 exactly in the cycle after `csN` and `rdN` are both sampled low. `dataOut` is 0 whenever `dataOe` is 0.
- R10: The status word is {pointer[1:0], low-byte-pending, new-result, 8'h00}. New-result sets on `convDone` and clears on the rising edge of a low-address read of the result. If both happen in the same cycle, the set wins. Low-byte-pending sets on a low-byte write and clears on a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe |
| hiByteSel | input | 1 | Byte select from the host's address bit 0 (1 = high byte) |
| dataIn | input | 8 | Write data byte |
| dataOut | output | 12 | Read data |
| dataOe | output | 1 | Read data is being driven |
| convDone | input | 1 | One-cycle pulse: a new conversion result is ready |
| convResult | input | 12 | Result word from the converter stub |

## Verification
The assertions assume the host behaves like a memory cycle:
- chip select, byte select and write data are held steady for the whole time a strobe is low, and one cycle beyond it;
- a read and a write never end in the same cycle.

The stimulus tasks assert chip select before the strobe and release it only after the strobe has risen. They hold data and byte select across that whole window and leave idle cycles between accesses. Strobes pulsed with chip select high come from a separate task, so that case is covered on purpose.

// File: rtl/adcRegPortPkg.sv
package adcRegPortPkg;
  localparam int BYTE_W = 8;
  localparam int DATA_W = 12;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [1:0] {
    PTR_RESULT  = 2'd0,
    PTR_STATUS  = 2'd1,
    PTR_CONTROL = 2'd2,
    PTR_TEST    = 2'd3
  } readPtr_t;

  typedef enum logic [1:0] {
    DST_TEST    = 2'd0,
    DST_CONTROL = 2'd1,
    DST_NONE_A  = 2'd2,
    DST_NONE_B  = 2'd3
  } destSel_t;

  typedef struct packed {
    logic              lowWr;      // low byte write completed
    logic              commit;     // high byte write completed
    logic [BYTE_W-1:0] wrByte;     // byte captured during the strobe
    logic              rdLowRise;  // low-address read completed
    logic              readHigh;   // current read targets the high byte
  } portStrobe_t;
endpackage

// File: rtl/adcPortCtrl.sv
module adcPortCtrl
  import adcRegPortPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              hiByteSel,
  input  logic [BYTE_W-1:0] dataIn,
  output portStrobe_t       strb,
  output logic              dataOe
);
  // first stage: the pins as sampled at the last edge
  logic sCsN, sRdN, sWrN, sHb;
  logic [BYTE_W-1:0] sData;
  // second stage: the stage above, one cycle older
  logic pCsN, pRdN, pWrN, pHb;
  logic [BYTE_W-1:0] pData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sCsN  <= 1'b1;
      sRdN  <= 1'b1;
      sWrN  <= 1'b1;
      sHb   <= 1'b0;
      sData <= '0;
      pCsN  <= 1'b1;
      pRdN  <= 1'b1;
      pWrN  <= 1'b1;
      pHb   <= 1'b0;
      pData <= '0;
    end else begin
      sCsN  <= csN;
      sRdN  <= rdN;
      sWrN  <= wrN;
      sHb   <= hiByteSel;
      sData <= dataIn;
      pCsN  <= sCsN;
      pRdN  <= sRdN;
      pWrN  <= sWrN;
      pHb   <= sHb;
      pData <= sData;
    end
  end

  logic wrRise, rdRise;
  assign wrRise = sWrN & ~pWrN & ~pCsN;
  assign rdRise = sRdN & ~pRdN & ~pCsN;

  always_comb begin
    strb.lowWr     = wrRise & ~pHb;
    strb.commit    = wrRise & pHb;
    strb.wrByte    = pData;
    strb.rdLowRise = rdRise & ~pHb;
    strb.readHigh  = sHb;
  end

  assign dataOe = ~sCsN & ~sRdN;

  // R9: the output enable follows the sampled pins by one cycle
  a_r9_oe_follows_pins: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> $past(!csN && !rdN));
  // R6: no action fires unless chip select was low during the strobe
  a_r6_cs_gates_actions: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lowWr || strb.commit || strb.rdLowRise) |-> $past(!csN, 2));
  // R2/R3: a completed write is either a low byte or a commit, never both
  a_r3_one_write_kind: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.lowWr, strb.commit}));
endmodule

// File: rtl/adcRegDatapath.sv
module adcRegDatapath
  import adcRegPortPkg::*;
#(
  parameter logic [DATA_W-1:0] TEST_DEFAULT = 12'h020,
  parameter logic [DATA_W-1:0] CTRL_DEFAULT = 12'h000
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobe_t       strb,
  input  logic              dataOe,
  input  logic              convDone,
  input  logic [DATA_W-1:0] convResult,
  output logic [DATA_W-1:0] dataOut
);
  localparam int NUM_WR   = 2;
  localparam int HI_BITS  = DATA_W - BYTE_W;
  localparam int DST_LSB  = WORD_W - 2;
  localparam int PTR_LSB  = WORD_W - 4;

  logic [BYTE_W-1:0] staging;
  logic              lowPending;
  logic              resultNew;
  logic [DATA_W-1:0] resultReg;
  readPtr_t          ptr;
  logic [DATA_W-1:0] regFile [NUM_WR];

  logic [WORD_W-1:0] word;
  destSel_t          dest;
  assign word = {strb.wrByte, staging};
  assign dest = destSel_t'(word[DST_LSB +: 2]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      staging    <= '0;
      lowPending <= 1'b0;
      ptr        <= PTR_RESULT;
    end else if (strb.lowWr) begin
      staging    <= strb.wrByte;
      lowPending <= 1'b1;
    end else if (strb.commit) begin
      lowPending <= 1'b0;
      ptr        <= readPtr_t'(word[PTR_LSB +: 2]);
    end
  end

  // writable registers: index 0 test, index 1 control
  for (genvar i = 0; i < NUM_WR; i++) begin : gRegs
    localparam logic [DATA_W-1:0] DEF = (i == 0) ? TEST_DEFAULT : CTRL_DEFAULT;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regFile[i] <= DEF;
      else if (strb.commit && (dest == destSel_t'(i)))
        regFile[i] <= word[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultReg <= '0;
      resultNew <= 1'b0;
    end else if (convDone) begin
      resultReg <= convResult;
      resultNew <= 1'b1;
    end else if (strb.rdLowRise && ptr == PTR_RESULT) begin
      resultNew <= 1'b0;
    end
  end

  logic [DATA_W-1:0] statusWord, selVal, muxOut;
  assign statusWord = {ptr, lowPending, resultNew, {(DATA_W-4){1'b0}}};

  always_comb begin
    unique case (ptr)
      PTR_RESULT:  selVal = resultReg;
      PTR_STATUS:  selVal = statusWord;
      PTR_CONTROL: selVal = regFile[1];
      default:     selVal = regFile[0];
    endcase
    if (strb.readHigh)
      muxOut = {{BYTE_W{1'b0}}, selVal[DATA_W-1 -: HI_BITS]};
    else if (ptr == PTR_RESULT || ptr == PTR_STATUS)
      muxOut = selVal;
    else
      muxOut = {{HI_BITS{1'b0}}, selVal[BYTE_W-1:0]};
  end

  assign dataOut = dataOe ? muxOut : '0;

  // R2: a staged low byte leaves the registers alone
  a_r2_low_no_commit: assert property (@(posedge clk) disable iff (!rstN)
    strb.lowWr |=> ($stable(regFile[0]) && $stable(regFile[1]) && $stable(ptr)));
  // R10: pending flag tracks staging
  a_r10_pending_set: assert property (@(posedge clk) disable iff (!rstN)
    strb.lowWr |=> lowPending);
  a_r10_pending_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> !lowPending);
  // R10: a new conversion always raises the flag
  a_r10_new_result: assert property (@(posedge clk) disable iff (!rstN)
    convDone |=> (resultNew && resultReg == $past(convResult)));
  // R4: restoring word brings back the default
  a_r4_restore: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && strb.wrByte == 8'h00 && staging == 8'h20) |=> regFile[0] == TEST_DEFAULT);
  // R9: quiet bus when not enabled
  a_r9_quiet_bus: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> dataOut == '0);
endmodule

// File: rtl/adcRegPort.sv
module adcRegPort
  import adcRegPortPkg::*;
#(
  parameter logic [11:0] TEST_DEFAULT = 12'h020
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        rdN,
  input  logic        wrN,
  input  logic        hiByteSel,
  input  logic [7:0]  dataIn,
  output logic [11:0] dataOut,
  output logic        dataOe,
  input  logic        convDone,
  input  logic [11:0] convResult
);
  portStrobe_t strb;

  adcPortCtrl uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN),
    .hiByteSel(hiByteSel), .dataIn(dataIn), .strb(strb), .dataOe(dataOe)
  );

  adcRegDatapath #(.TEST_DEFAULT(TEST_DEFAULT)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .dataOe(dataOe),
    .convDone(convDone), .convResult(convResult), .dataOut(dataOut)
  );
endmodule

// File: tb/tb_adcRegPort.sv
module tb_adcRegPort;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, rdN = 1'b1, wrN = 1'b1, hiByteSel = 1'b0;
  logic [7:0] dataIn = '0;
  logic [11:0] dataOut;
  logic dataOe;
  logic convDone = 1'b0;
  logic [11:0] convResult = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  adcRegPort dut (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN),
    .hiByteSel(hiByteSel), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .convDone(convDone), .convResult(convResult)
  );

  // behavioural reference model
  logic [11:0] mCtrl, mTest, mRes;
  logic [1:0]  mPtr;
  logic [7:0]  mStage;
  logic        mPend, mNew;
  logic [11:0] pinQ [$];   // {cs,rd,wr,hb,data}
  logic [11:0] h0, h1;
  logic [15:0] mWord;
  logic        mWrRise, mRdRise;

  function automatic logic [11:0] modelOut();
    logic [11:0] v;
    case (mPtr)
      2'd0: v = mRes;
      2'd1: v = {mPtr, mPend, mNew, 8'h00};
      2'd2: v = mCtrl;
      default: v = mTest;
    endcase
    if (h0[8]) return {8'h00, v[11:8]};
    if (mPtr < 2) return v;
    return {4'h0, v[7:0]};
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = '0; mTest = 12'h020; mRes = '0; mPtr = '0;
      mStage = '0; mPend = 0; mNew = 0;
      h0 = 12'hE00; h1 = 12'hE00;
      pinQ.delete();
    end else begin
      mWrRise = h0[9] && !h1[9] && !h1[11];
      mRdRise = h0[10] && !h1[10] && !h1[11];
      if (mWrRise && !h1[8]) begin
        mStage = h1[7:0]; mPend = 1;
      end else if (mWrRise) begin
        mWord = {h1[7:0], mStage};
        mPend = 0;
        mPtr = mWord[13:12];
        if (mWord[15:14] == 2'b00) mTest = mWord[11:0];
        else if (mWord[15:14] == 2'b01) mCtrl = mWord[11:0];
      end
      if (mRdRise && !h1[8] && mPtr == 2'd0) mNew = 0;
      if (convDone) begin mRes = convResult; mNew = 1; end
      pinQ.push_back({csN, rdN, wrN, hiByteSel, dataIn});
      h1 = h0;
      h0 = pinQ.pop_front();
    end
  end

  // every-cycle comparison against the model (R9 and read data R7/R8)
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (dataOe !== (!h0[11] && !h0[10])) begin
        errors++;
        $display("FAIL R9 oe actual %0b expected %0b", dataOe, (!h0[11] && !h0[10]));
      end
      checks++;
      if (dataOut !== (dataOe ? modelOut() : 12'h000)) begin
        errors++;
        $display("FAIL R8 model data actual %h expected %h", dataOut,
                 (dataOe ? modelOut() : 12'h000));
      end
    end
  end

  task automatic check(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrByte(logic hb, logic [7:0] b, logic useCs = 1'b1);
    @(negedge clk);
    csN = ~useCs; hiByteSel = hb; dataIn = b;
    @(negedge clk); wrN = 1'b0;
    idle(2);
    wrN = 1'b1;
    idle(1);
    csN = 1'b1;
    idle(2);
  endtask

  task automatic wrWord(logic [15:0] w);
    wrByte(1'b0, w[7:0]);
    wrByte(1'b1, w[15:8]);
  endtask

  task automatic rdPort(logic hb, output logic [11:0] v);
    @(negedge clk);
    csN = 1'b0; hiByteSel = hb;
    @(negedge clk); rdN = 1'b0;
    idle(3);
    v = dataOut;
    rdN = 1'b1;
    idle(1);
    csN = 1'b1;
    idle(2);
  endtask

  logic [11:0] rv;

  initial begin
    idle(3);
    check("R1 oe", {11'h0, dataOe}, 12'h000);
    check("R1 data", dataOut, 12'h000);
    rstN = 1'b1;
    idle(2);
    // R1: default status and test register
    wrWord(16'hD000);
    rdPort(1'b0, rv); check("R1 status", rv, 12'h400);
    wrWord(16'hF000);
    rdPort(1'b0, rv); check("R1 test default", rv, 12'h020);
    rdPort(1'b1, rv); check("R8 test high", rv, 12'h000);
    // R3: control write with pointer to control
    wrWord(16'h65A7);
    rdPort(1'b0, rv); check("R3 control low", rv, 12'h0A7);
    rdPort(1'b1, rv); check("R3 control high", rv, 12'h005);
    // R2: staged low byte changes nothing
    wrByte(1'b0, 8'h33);
    rdPort(1'b0, rv); check("R2 no early commit", rv, 12'h0A7);
    wrByte(1'b1, 8'h61);
    rdPort(1'b0, rv); check("R3 commit", rv, 12'h033);
    rdPort(1'b1, rv); check("R3 commit high", rv, 12'h001);
    // R5: high byte alone reuses staging
    wrByte(1'b1, 8'h62);
    rdPort(1'b0, rv); check("R5 stale low", rv, 12'h033);
    rdPort(1'b1, rv); check("R5 new high", rv, 12'h002);
    // R6: strobes without chip select
    wrByte(1'b0, 8'h00, 1'b0);
    wrByte(1'b1, 8'h40, 1'b0);
    rdPort(1'b0, rv); check("R6 ignored low", rv, 12'h033);
    rdPort(1'b1, rv); check("R6 ignored high", rv, 12'h002);
    // R4: corrupt test register then restore
    wrWord(16'h0ABC);
    wrWord(16'hF000);
    rdPort(1'b0, rv); check("R8 test low", rv, 12'h0BC);
    rdPort(1'b1, rv); check("R8 test high", rv, 12'h00A);
    wrWord(16'h0020);
    wrWord(16'hF000);
    rdPort(1'b0, rv); check("R4 restored", rv, 12'h020);
    // R10/R7: conversion result and status flags
    @(negedge clk); convResult = 12'hC3D; convDone = 1'b1;
    @(negedge clk); convDone = 1'b0;
    wrWord(16'hD000);
    rdPort(1'b0, rv); check("R10 new set", rv, 12'h500);
    rdPort(1'b1, rv); check("R8 status high", rv, 12'h005);
    wrWord(16'hC000);
    rdPort(1'b1, rv); check("R8 result high", rv, 12'h00C);
    rdPort(1'b0, rv); check("R7 result full", rv, 12'hC3D);
    wrWord(16'hD000);
    rdPort(1'b0, rv); check("R10 new cleared", rv, 12'h400);
    wrByte(1'b0, 8'h55);
    rdPort(1'b0, rv); check("R10 pending", rv, 12'h600);
    wrByte(1'b1, 8'hD0);
    rdPort(1'b0, rv); check("R10 pending clear", rv, 12'h400);
    // R9: idle bus
    idle(2);
    check("R9 idle oe", {11'h0, dataOe}, 12'h000);
    check("R9 idle data", dataOut, 12'h000);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule